// File: doc/BRIEF.md
# Supply Supervisor Reset and Watchdog Controller

This block is the digital core of a power-supervisor die. Analog comparators outside the block supply three flags: one for the main supply being below its trip point, and under-voltage and over-voltage flags for a second sensed rail. The block filters these flags and drives a complementary pair of reset outputs. It also drives a separate active-low low-voltage flag that can serve as an interrupt or be wired onto the reset net.

Three sources start or restart the reset pulse:
- a qualified supply fault;
- a low level on the shared reset line, driven by another device;
- expiry of the watchdog, which must be serviced periodically.

Every duration is a parameter counted in clock cycles, so one netlist covers slow production timing and a short setting for test. The shared line is sampled through a two-flop synchronizer. Its value is ignored while the block itself drives the line low, and for the synchronizer latency after that drive ends, so the block never mistakes its own drive for an outside request.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_n` is low and after it rises, `rst_o`=1, `rst_n_o`=0 and `lowv_n_o`=1. The power-up pulse releases after `PULSE_CYC` clock edges.
- R2: `rst_n_o` is always the inverse of `rst_o`.
- R3: The reset is asserted at the clock edge that samples `vcc_low_i` high for the `GLITCH_CYC`-th consecutive time. A run of fewer consecutive high samples produces no reset.
- R4: Once asserted, the reset releases after `PULSE_CYC` consecutive edges with no trigger. Any trigger during that time restarts the count from zero.
- R5: `line_n_i` passes through two synchronizer flops. A low sample becomes a trigger two edges later, provided the block is not driving the line at that point. Each further low sample restarts the pulse count.
- R6: The synchronized line is ignored while the reset is asserted and for the two edges after it releases. A released line therefore causes no new reset.
- R7: The watchdog count is held at zero while the reset is asserted and is cleared by any edge that samples `wd_kick_i` high. If `WD_CYC` consecutive edges pass with the reset released and no service, the reset is triggered.
- R8: `lowv_n_o` goes low after `LV_DLY_CYC` consecutive samples with `sense_uv_i` or `sense_ov_i` high. It goes high after `LV_DLY_CYC` consecutive samples with both flags low. Shorter runs leave it unchanged.
- R9: `lowv_n_o` follows R8 whatever the reset state, including while the reset is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low power-on reset of the logic |
| vcc_low_i | input | 1 | Main supply below trip point, from comparator |
| sense_uv_i | input | 1 | Second rail under-voltage flag |
| sense_ov_i | input | 1 | Second rail over-voltage flag |
| line_n_i | input | 1 | Received level of the shared active-low reset line |
| wd_kick_i | input | 1 | Watchdog service strobe, one cycle per service |
| rst_o | output | 1 | Active-high reset |
| rst_n_o | output | 1 | Active-low reset, drive for the shared line |
| lowv_n_o | output | 1 | Active-low second-rail fault flag |

## Verification
The embedded assertions check several rules on every cycle:
- a reset never releases before its count is complete;
- a supply trigger always lands in the reset state with a cleared count;
- the watchdog count is zero after any reset cycle or service;
- the low-voltage flag only moves in the direction its input has been showing;
- the line is never read as a request right after the block releases it.

Other behaviour only shows up through the bench's scenarios. This covers the exact edge at which a reset begins and ends under interleaved supply faults, line pulls and missed services. It also covers the glitch length just below the threshold and the independence of the flag from an active reset. The bench checks these against its own cycle model of the requirements.

// File: rtl/supv_pkg.sv
package supv_pkg;
    // Number of flops in the shared-line synchronizer; also the blanking
    // window after release, so the block never sees its own drive.
    localparam int unsigned SYNC_DEPTH = 2;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction
endpackage

// File: rtl/supv_glitch_filter.sv
module supv_glitch_filter #(
    parameter int unsigned HOLD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic fault_o
);
    localparam int unsigned CW = supv_pkg::cnt_width(HOLD_CYC);
    localparam logic [CW-1:0] TOP = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } gf_state_t;

    gf_state_t st_d, st_q;
    logic at_top;

    always_comb begin
        st_d    = st_q;
        at_top  = (st_q.run == TOP);
        fault_o = raw_i && at_top;
        if (!raw_i)
            st_d.run = '0;
        else if (!at_top)
            st_d.run = st_q.run + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (HOLD_CYC > 1) begin : g_chk
            // R3
            first_sample_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(raw_i) |-> !fault_o);
        end
    endgenerate

    // R3
    fault_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o && raw_i |=> fault_o || !raw_i);
endmodule

// File: rtl/supv_level_delay.sv
module supv_level_delay #(
    parameter int unsigned DLY_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sense_i,
    output logic flag_o
);
    localparam int unsigned CW = supv_pkg::cnt_width(DLY_CYC);
    localparam logic [CW-1:0] TOP = CW'(DLY_CYC - 1);

    typedef struct packed {
        logic          lv;
        logic [CW-1:0] cnt;
    } ld_state_t;

    ld_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sense_i != st_q.lv) begin
            if (st_q.cnt == TOP) begin
                st_d.lv  = sense_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.lv;

    // R8
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(sense_i));
    // R8
    flag_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_o) |-> !$past(sense_i));
endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog #(
    parameter int unsigned PERIOD_CYC = 40,
    parameter bit          EN         = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic kick_i,
    output logic expire_o
);
    localparam int unsigned CW = supv_pkg::cnt_width(PERIOD_CYC);
    localparam logic [CW-1:0] TOP = CW'(PERIOD_CYC - 1);

    generate
        if (EN) begin : g_wd
            typedef struct packed {
                logic [CW-1:0] cnt;
            } wd_state_t;

            wd_state_t st_d, st_q;

            always_comb begin
                st_d     = st_q;
                expire_o = !hold_i && !kick_i && (st_q.cnt == TOP);
                if (hold_i || kick_i || expire_o)
                    st_d.cnt = '0;
                else
                    st_d.cnt = st_q.cnt + 1'b1;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            // R7
            held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hold_i || kick_i |=> st_q.cnt == '0);
        end else begin : g_nowd
            assign expire_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
    parameter int unsigned GLITCH_CYC = 3,
    parameter int unsigned LV_DLY_CYC = 4,
    parameter int unsigned PULSE_CYC  = 2000000,
    parameter int unsigned WD_CYC     = 16000000,
    parameter bit          WD_EN      = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_low_i,
    input  logic sense_uv_i,
    input  logic sense_ov_i,
    input  logic line_n_i,
    input  logic wd_kick_i,
    output logic rst_o,
    output logic rst_n_o,
    output logic lowv_n_o
);
    import supv_pkg::*;

    localparam int unsigned PW = cnt_width(PULSE_CYC);
    localparam logic [PW-1:0] PTOP = PW'(PULSE_CYC - 1);
    localparam int unsigned BW = $clog2(SYNC_DEPTH + 1);
    localparam logic [BW-1:0] BLANK = BW'(SYNC_DEPTH);

    typedef struct packed {
        logic [SYNC_DEPTH-1:0] sync;
        logic [BW-1:0]         blank;
        logic                  rst;
        logic [PW-1:0]         pcnt;
    } rc_state_t;

    rc_state_t st_d, st_q;

    logic vcc_fault, wd_expire, lv_flag;
    logic line_s, ext_req, trig;

    supv_glitch_filter #(.HOLD_CYC(GLITCH_CYC)) u_glitch (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (vcc_low_i),
        .fault_o (vcc_fault)
    );

    supv_watchdog #(.PERIOD_CYC(WD_CYC), .EN(WD_EN)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (st_q.rst),
        .kick_i   (wd_kick_i),
        .expire_o (wd_expire)
    );

    supv_level_delay #(.DLY_CYC(LV_DLY_CYC)) u_lowv (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_i (sense_uv_i || sense_ov_i),
        .flag_o  (lv_flag)
    );

    always_comb begin
        st_d    = st_q;
        line_s  = st_q.sync[SYNC_DEPTH-1];
        ext_req = !line_s && !st_q.rst && (st_q.blank == '0);
        trig    = vcc_fault || ext_req || wd_expire;

        st_d.sync = {st_q.sync[SYNC_DEPTH-2:0], line_n_i};

        if (st_q.rst)
            st_d.blank = BLANK;
        else if (st_q.blank != '0)
            st_d.blank = st_q.blank - 1'b1;

        if (trig) begin
            st_d.rst  = 1'b1;
            st_d.pcnt = '0;
        end else if (st_q.rst) begin
            if (st_q.pcnt == PTOP) begin
                st_d.rst  = 1'b0;
                st_d.pcnt = '0;
            end else begin
                st_d.pcnt = st_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sync  <= '1;
            st_q.blank <= '0;
            st_q.rst   <= 1'b1;
            st_q.pcnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o    = st_q.rst;
    assign rst_n_o  = ~st_q.rst;
    assign lowv_n_o = ~lv_flag;

    // R4
    full_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rst) |-> $past(st_q.pcnt) == PTOP);
    // R3
    supply_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_fault |=> st_q.rst && st_q.pcnt == '0);
    // R6
    no_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rst) |-> !ext_req);
    // R7
    wd_idle_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst |-> !wd_expire);
endmodule

// File: tb/supv_reset_ctrl_bench.sv
module supv_reset_ctrl_bench;
    localparam int G  = 3;
    localparam int LV = 4;
    localparam int P  = 10;
    localparam int WD = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_low = 1'b0, uv = 1'b0, ov = 1'b0, kick = 1'b0, pull = 1'b0;
    logic rst_o, rst_n_o, lowv_n_o;
    logic line_n;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    // Shared open-drain line: low if the block or the outside pulls it.
    assign line_n = rst_n_o & ~pull;

    supv_reset_ctrl #(
        .GLITCH_CYC(G), .LV_DLY_CYC(LV), .PULSE_CYC(P), .WD_CYC(WD), .WD_EN(1'b1)
    ) u_supv_reset_ctrl (
        .clk(clk), .rst_n(rst_n), .vcc_low_i(vcc_low), .sense_uv_i(uv),
        .sense_ov_i(ov), .line_n_i(line_n), .wd_kick_i(kick),
        .rst_o(rst_o), .rst_n_o(rst_n_o), .lowv_n_o(lowv_n_o)
    );

    // Reference model built from the requirements.
    bit m_rst = 1, m_lv = 0, m_h1 = 1, m_h2 = 1;
    int m_vrun = 0, m_quiet = 0, m_since = 0, m_idle = 0, m_lc = 0;

    function automatic bit qual_supply(bit v, int run);
        return v && (run + 1 >= G);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst = 1; m_quiet = 0; m_vrun = 0; m_h1 = 1; m_h2 = 1;
            m_since = 0; m_idle = 0; m_lv = 0; m_lc = 0;
        end else begin
            bit pad, vq, ereq, wexp, trig, bad;
            pad  = !m_rst && !pull;
            vq   = qual_supply(vcc_low, m_vrun);
            m_vrun = vcc_low ? m_vrun + 1 : 0;
            ereq = !m_rst && (m_since >= 2) && !m_h2;
            wexp = !m_rst && !kick && (m_idle == WD - 1);
            m_idle  = (m_rst || kick || wexp) ? 0 : m_idle + 1;
            m_since = m_rst ? 0 : ((m_since < 10) ? m_since + 1 : m_since);
            m_h2 = m_h1; m_h1 = pad;
            trig = vq || ereq || wexp;
            if (trig) begin
                m_rst = 1; m_quiet = 0;
            end else if (m_rst) begin
                m_quiet++;
                if (m_quiet == P) begin m_rst = 0; m_quiet = 0; end
            end
            bad = uv || ov;
            if (bad != m_lv) begin
                m_lc++;
                if (m_lc == LV) begin m_lv = bad; m_lc = 0; end
            end else m_lc = 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    bit run_cmp = 0;
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            check(rst_o == m_rst, "R3/R4/R5/R6/R7 reset level", rst_o, m_rst);
            check(rst_n_o == !rst_o, "R2 complementary", rst_n_o, !rst_o);
            check(lowv_n_o == !m_lv, "R8/R9 lowv flag", lowv_n_o, !m_lv);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done = 0;
    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    errors++; checks++;
                    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        void'($urandom(32'd2024));
        step(3);
        // R1: held during logic reset
        check(rst_o == 1 && rst_n_o == 0, "R1 reset during rst_n", rst_o, 1);
        check(lowv_n_o == 1, "R1 lowv idle", lowv_n_o, 1);
        rst_n = 1'b1; kick = 1'b1;
        run_cmp = 1;
        step(P - 1);
        check(rst_o == 1, "R1 power-up pulse held", rst_o, 1);
        step(1);
        check(rst_o == 0, "R1 power-up pulse released", rst_o, 0);
        step(3);
        // R3: glitch of G-1 samples ignored
        vcc_low = 1; step(G - 1); vcc_low = 0; step(4);
        check(rst_o == 0, "R3 short glitch ignored", rst_o, 0);
        // R3: G samples qualifies
        vcc_low = 1; step(G);
        check(rst_o == 1, "R3 qualified fault", rst_o, 1);
        vcc_low = 0; step(P - 1);
        check(rst_o == 1, "R4 timeout not yet done", rst_o, 1);
        step(1);
        check(rst_o == 0, "R4 timeout done", rst_o, 0);
        // R4: retrigger mid-timeout restarts count
        vcc_low = 1; step(G); vcc_low = 0; step(P / 2);
        vcc_low = 1; step(G); vcc_low = 0; step(P - 1);
        check(rst_o == 1, "R4 restart extends pulse", rst_o, 1);
        step(1);
        check(rst_o == 0, "R4 restarted pulse ends", rst_o, 0);
        step(4);
        // R5: external pull
        pull = 1; step(3);
        check(rst_o == 1, "R5 external pull asserts", rst_o, 1);
        pull = 0;
        step(P + 2);
        check(rst_o == 0, "R5 external pulse finished", rst_o, 0);
        // R6: released line does not retrigger
        step(6);
        check(rst_o == 0, "R6 no readback of own drive", rst_o, 0);
        // R7: missed service
        kick = 0; step(WD - 1);
        check(rst_o == 0, "R7 before expiry", rst_o, 0);
        step(1);
        check(rst_o == 1, "R7 expiry asserts reset", rst_o, 1);
        kick = 1; step(P + 2);
        // R8: short under-voltage ignored, long one flagged
        uv = 1; step(LV - 1); uv = 0; step(2);
        check(lowv_n_o == 1, "R8 short under-voltage ignored", lowv_n_o, 1);
        ov = 1; step(LV);
        check(lowv_n_o == 0, "R8 over-voltage flagged", lowv_n_o, 0);
        ov = 0; step(LV);
        check(lowv_n_o == 1, "R8 flag released", lowv_n_o, 1);
        // R9: flag moves while reset held
        vcc_low = 1; step(G); uv = 1; step(LV);
        check(rst_o == 1 && lowv_n_o == 0, "R9 flag during reset", lowv_n_o, 0);
        uv = 0; step(LV);
        check(rst_o == 1 && lowv_n_o == 1, "R9 flag release during reset", lowv_n_o, 1);
        vcc_low = 0; step(P + 2);
        // Constrained random phase
        begin
            int vrun = 0, prun = 0;
            for (int i = 0; i < 6000; i++) begin
                int r;
                r = $urandom % 100;
                if (vrun > 0) vrun--; else if (r < 3) vrun = 1 + $urandom % 6;
                vcc_low = (vrun > 0);
                r = $urandom % 100;
                if (prun > 0) prun--; else if (r < 2) prun = 1 + $urandom % 5;
                pull = (prun > 0);
                if ($urandom % 8 == 0) uv = ~uv;
                if ($urandom % 10 == 0) ov = ~ov;
                kick = ($urandom % 100) < 4;
                step(1);
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule